// File: doc/BRIEF.md
# Byte-Stream Framer with Emulation Prevention

This block turns a stream of network-abstraction-layer unit payloads into a framed byte stream. Each payload arrives as a sequence of 16-bit words, and each word carries one or two valid bytes. A start flag on the first word of a unit makes the block emit a four-byte start code and a one-byte unit header before the payload. While the payload passes through, the block watches for runs of zero bytes. Wherever the payload would otherwise contain a pattern that a decoder could mistake for a start code, it inserts an escape byte.

The output is a 32-bit word bus with one enable per byte lane and a valid/ready handshake. An internal byte buffer absorbs the growth caused by framing and escaping. A unit always closes on its own output word, so that the next start code begins on lane 0. The input side is throttled whenever the buffer could not take the largest expansion of one input word.

Top module: `annexb_stream_packer`

## Requirements
- R1: After reset, `out_valid` is low, `out_be` is 0 and `in_ready` is high.
- R2: Every unit begins with the bytes 0x00, 0x00, 0x00, 0x01. The first of these sits in output lane 0, which is `out_data[31:24]`.
- R3: The byte after the start code is `{1'b0, ref_idc[1:0], type[4:0]}`. `ref_idc` is 3 for types 5, 7 and 8, 2 for type 1, and 0 for any other type. The header values are therefore 0x65, 0x67, 0x68 and 0x41.
- R4: After two consecutive payload zero bytes, if the next payload byte is 0x00, 0x01, 0x02 or 0x03, the block emits 0x03 before that byte. The zero-run count then restarts from that byte.
- R5: The zero-run count carries across input word boundaries. It is cleared at each unit start, and the start code and header bytes do not add to it.
- R6: A word with `in_nbytes`=2 carries `in_data[15:8]` first and `in_data[7:0]` second. A word with `in_nbytes`=1 carries only `in_data[15:8]`.
- R7: Output bytes leave in stream order, from lane 0 (`out_data[31:24]`) to lane 3 (`out_data[7:0]`). `out_be[3]` marks lane 0. Every word that does not end a unit carries four bytes with `out_be`=4'b1111.
- R8: A unit's final byte is flushed without waiting for more input. The word that carries it has `out_last` high and its enables set only for lanes 0 up to that byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_be` and `out_last` hold their values.
- R10: With the default 16-byte buffer, `in_ready` is high only while the buffer holds at most 8 bytes, which is the worst-case growth of one word. No accepted byte is lost under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 16 | Payload bytes, first byte in [15:8] |
| in_nbytes | input | 2 | Number of valid bytes in the word (1 or 2) |
| in_first | input | 1 | Word is the first of a unit |
| in_last | input | 1 | Word holds the last byte of a unit |
| in_type | input | 5 | Unit type, sampled with `in_first` |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Output bytes, first byte in [31:24] |
| out_be | output | 4 | Byte-lane enables, bit 3 for lane 0 |
| out_last | output | 1 | Word carries the final byte of a unit |

## Verification
Two functions can fall in the same cycle. One is the prefix and header for a new unit, written into the buffer. The other is an escape byte due on the first payload byte of that same word. A related case arises when one side of a word completes a zero run and the other side needs the escape. The bench provokes these with payloads that open on low byte values, with zero pairs split across word boundaries, and with units that end in zeros and are followed at once by a unit whose first byte is 0x01 or 0x02. A scoreboard model, written separately from the design, predicts every byte, lane and last flag. Pseudo-random stalls on `out_ready` exercise the hold rule, and a long stall checks where `in_ready` falls.

// File: rtl/annexb_pkg.sv
package annexb_pkg;
   localparam int PREFIX_BYTES = 5;

   function automatic logic [7:0] hdr_byte(input logic [4:0] t);
      logic [1:0] ref_idc;
      case (t)
         5'd5, 5'd7, 5'd8: ref_idc = 2'd3;
         5'd1:             ref_idc = 2'd2;
         default:          ref_idc = 2'd0;
      endcase
      return {1'b0, ref_idc, t};
   endfunction
endpackage

// File: rtl/annexb_escape.sv
module annexb_escape
   import annexb_pkg::*;
#(
   parameter int IN_BYTES = 2,
   parameter int MAX_OUT  = 8,
   localparam int NBW     = $clog2(IN_BYTES + 1),
   localparam int CW      = $clog2(MAX_OUT + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fire,
   input  logic                         first,
   input  logic [4:0]                   ntype,
   input  logic [NBW-1:0]               nbytes,
   input  logic [8*IN_BYTES-1:0]        data,
   output logic [MAX_OUT-1:0][7:0]      o_bytes,
   output logic [CW-1:0]                o_count
);
   logic [1:0] zrun_q, zrun_n;

   always_comb begin
      logic [1:0]  zc;
      logic [7:0]  b;
      int          n;
      o_bytes = '0;
      n       = 0;
      zc      = first ? 2'd0 : zrun_q;
      if (first) begin
         o_bytes[0] = 8'h00;
         o_bytes[1] = 8'h00;
         o_bytes[2] = 8'h00;
         o_bytes[3] = 8'h01;
         o_bytes[4] = hdr_byte(ntype);
         n = PREFIX_BYTES;
      end
      for (int i = 0; i < IN_BYTES; i++) begin
         b = data[8*(IN_BYTES-1-i) +: 8];
         if (i < int'(nbytes)) begin
            if (zc == 2'd2 && b <= 8'h03) begin
               o_bytes[n] = 8'h03;
               n  = n + 1;
               zc = 2'd0;
            end
            o_bytes[n] = b;
            n  = n + 1;
            zc = (b == 8'h00) ? zc + 2'd1 : 2'd0;
         end
      end
      zrun_n  = zc;
      o_count = CW'(n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    zrun_q <= 2'd0;
      else if (fire) zrun_q <= zrun_n;
   end

   a_r5_zrun_bound: assert property (@(posedge clk) disable iff (!rst_n)
      zrun_q <= 2'd2);
   a_r4_escape_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !first && zrun_q == 2'd2 && nbytes != '0 &&
       data[8*IN_BYTES-1 -: 8] <= 8'h03) |-> (o_bytes[0] == 8'h03));
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(o_count) <= MAX_OUT);
endmodule

// File: rtl/annexb_buffer.sv
module annexb_buffer #(
   parameter int DEPTH    = 16,
   parameter int PUSH_MAX = 8,
   parameter int POP_MAX  = 4,
   localparam int CNTW    = $clog2(DEPTH + 1),
   localparam int PSW     = $clog2(PUSH_MAX + 1),
   localparam int PPW     = $clog2(POP_MAX + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [PSW-1:0]             push_n,
   input  logic [PUSH_MAX-1:0][7:0]   push_bytes,
   input  logic                       push_last,
   input  logic [PPW-1:0]             pop_n,
   output logic [POP_MAX-1:0][7:0]    head,
   output logic [POP_MAX-1:0]         head_last,
   output logic [CNTW-1:0]            count
);
   logic [DEPTH-1:0][7:0] mem_q, mem_n;
   logic [DEPTH-1:0]      lst_q, lst_n;
   logic [CNTW-1:0]       count_q;

   always_comb begin
      int src;
      int base;
      for (int j = 0; j < DEPTH; j++) begin
         src = j + int'(pop_n);
         if (src < DEPTH) begin
            mem_n[j] = mem_q[src];
            lst_n[j] = lst_q[src];
         end else begin
            mem_n[j] = 8'h00;
            lst_n[j] = 1'b0;
         end
      end
      base = int'(count_q) - int'(pop_n);
      for (int k = 0; k < PUSH_MAX; k++) begin
         if (k < int'(push_n) && base + k < DEPTH && base + k >= 0) begin
            mem_n[base+k] = push_bytes[k];
            lst_n[base+k] = push_last && (k == int'(push_n) - 1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= '0;
         lst_q   <= '0;
         count_q <= '0;
      end else begin
         mem_q   <= mem_n;
         lst_q   <= lst_n;
         count_q <= CNTW'(int'(count_q) - int'(pop_n) + int'(push_n));
      end
   end

   for (genvar g = 0; g < POP_MAX; g++) begin : g_head
      assign head[g]      = mem_q[g];
      assign head_last[g] = lst_q[g];
   end
   assign count = count_q;

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count_q) - int'(pop_n) + int'(push_n) <= DEPTH);
   a_r10_pop_avail: assert property (@(posedge clk) disable iff (!rst_n)
      pop_n <= count_q);
endmodule

// File: rtl/annexb_pack.sv
module annexb_pack #(
   parameter int OUT_BYTES = 4,
   parameter int CNTW      = 5,
   localparam int PPW      = $clog2(OUT_BYTES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [OUT_BYTES-1:0][7:0]   head,
   input  logic [OUT_BYTES-1:0]        head_last,
   input  logic [CNTW-1:0]             count,
   input  logic                        out_ready,
   output logic                        out_valid,
   output logic [8*OUT_BYTES-1:0]      out_data,
   output logic [OUT_BYTES-1:0]        out_be,
   output logic                        out_last,
   output logic [PPW-1:0]              pop_n
);
   logic [PPW-1:0] take;
   logic           found;

   always_comb begin
      found = 1'b0;
      take  = '0;
      for (int k = 0; k < OUT_BYTES; k++) begin
         if (!found && k < int'(count) && head_last[k]) begin
            found = 1'b1;
            take  = PPW'(k + 1);
         end
      end
      if (!found) take = (int'(count) >= OUT_BYTES) ? PPW'(OUT_BYTES) : '0;
   end

   for (genvar g = 0; g < OUT_BYTES; g++) begin : g_lane
      assign out_be[OUT_BYTES-1-g]           = (g < int'(take));
      assign out_data[8*(OUT_BYTES-1-g) +: 8] = (g < int'(take)) ? head[g] : 8'h00;
   end

   assign out_valid = (take != '0);
   assign out_last  = found;
   assign pop_n     = (out_valid && out_ready) ? take : '0;

   a_r7_full_word: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> (out_be == {OUT_BYTES{1'b1}}));
   a_r8_lane0_used: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_be[OUT_BYTES-1]);
endmodule

// File: rtl/annexb_stream_packer.sv
module annexb_stream_packer
   import annexb_pkg::*;
#(
   parameter int IN_BYTES  = 2,
   parameter int OUT_BYTES = 4,
   parameter int BUF_BYTES = 16,
   localparam int NBW      = $clog2(IN_BYTES + 1),
   localparam int WORST    = PREFIX_BYTES + IN_BYTES + (IN_BYTES + 1) / 2,
   localparam int CW       = $clog2(WORST + 1),
   localparam int CNTW     = $clog2(BUF_BYTES + 1),
   localparam int PPW      = $clog2(OUT_BYTES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [8*IN_BYTES-1:0]     in_data,
   input  logic [NBW-1:0]            in_nbytes,
   input  logic                      in_first,
   input  logic                      in_last,
   input  logic [4:0]                in_type,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [8*OUT_BYTES-1:0]    out_data,
   output logic [OUT_BYTES-1:0]      out_be,
   output logic                      out_last
);
   if (OUT_BYTES < 1 || OUT_BYTES > 4) begin : g_bad_out
      $error("OUT_BYTES must lie in 1..4");
   end
   if (BUF_BYTES < WORST + OUT_BYTES) begin : g_bad_buf
      $error("BUF_BYTES too small for worst-case expansion");
   end

   logic                     fire;
   logic [WORST-1:0][7:0]    esc_bytes;
   logic [CW-1:0]            esc_count;
   logic [CW-1:0]            push_n;
   logic [PPW-1:0]           pop_n;
   logic [OUT_BYTES-1:0][7:0] head;
   logic [OUT_BYTES-1:0]     head_last;
   logic [CNTW-1:0]          count;

   assign in_ready = int'(count) <= BUF_BYTES - WORST;
   assign fire     = in_valid && in_ready;
   assign push_n   = fire ? esc_count : '0;

   annexb_escape #(.IN_BYTES(IN_BYTES), .MAX_OUT(WORST)) esc_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .first(in_first),
      .ntype(in_type), .nbytes(in_nbytes), .data(in_data),
      .o_bytes(esc_bytes), .o_count(esc_count));

   annexb_buffer #(.DEPTH(BUF_BYTES), .PUSH_MAX(WORST), .POP_MAX(OUT_BYTES)) buf_i (
      .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_bytes(esc_bytes),
      .push_last(in_last), .pop_n(pop_n), .head(head), .head_last(head_last),
      .count(count));

   annexb_pack #(.OUT_BYTES(OUT_BYTES), .CNTW(CNTW)) pack_i (
      .clk(clk), .rst_n(rst_n), .head(head), .head_last(head_last),
      .count(count), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .out_be(out_be), .out_last(out_last), .pop_n(pop_n));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_be) && $stable(out_last)));
   a_r10_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (int'(count) + WORST <= BUF_BYTES));
endmodule

// File: tb/annexb_stream_packer_tb.sv
module annexb_stream_packer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic [1:0]  in_nbytes = 2'd0;
   logic        in_first = 1'b0;
   logic        in_last = 1'b0;
   logic [4:0]  in_type = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic [3:0]  out_be;
   logic        out_last;

   always #2.5 clk = ~clk;

   annexb_stream_packer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_nbytes(in_nbytes), .in_first(in_first),
      .in_last(in_last), .in_type(in_type), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
      .out_last(out_last));

   typedef struct {
      logic [7:0] b;
      bit         last;
      bit         first;
      int         req;
   } exp_t;

   exp_t        expq[$];
   int          errors = 0;
   int          checks = 0;
   int          exp_zc = 0;
   bit          stall = 1'b1;
   bit          mon_on = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;
   int          cycles = 0;
   bit          done = 1'b0;

   function automatic logic [7:0] exp_hdr(input logic [4:0] t);
      logic [1:0] r;
      r = (t == 5'd5 || t == 5'd7 || t == 5'd8) ? 2'd3 : (t == 5'd1) ? 2'd2 : 2'd0;
      return {1'b0, r, t};
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic push_exp(input logic [7:0] b, input bit l, input bit f, input int r);
      exp_t e;
      e.b = b; e.last = l; e.first = f; e.req = r;
      expq.push_back(e);
   endtask

   // Scoreboard driver: predicts bytes once acceptance is certain (R2 R3 R4 R5 R6)
   task automatic drive_word(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                             input bit f, input bit l, input logic [4:0] t);
      logic [7:0] bs[2];
      in_data = {b0, b1}; in_nbytes = 2'(nb); in_first = f; in_last = l;
      in_type = t; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      bs[0] = b0; bs[1] = b1;
      if (f) begin
         push_exp(8'h00, 0, 1, 2); push_exp(8'h00, 0, 0, 2);
         push_exp(8'h00, 0, 0, 2); push_exp(8'h01, 0, 0, 2);
         push_exp(exp_hdr(t), 0, 0, 3);
         exp_zc = 0;
      end
      for (int i = 0; i < nb; i++) begin
         if (exp_zc == 2 && bs[i] <= 8'h03) begin
            push_exp(8'h03, 0, 0, 4);
            exp_zc = 0;
         end
         push_exp(bs[i], l && (i == nb - 1), 0, 5);
         exp_zc = (bs[i] == 8'h00) ? exp_zc + 1 : 0;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_nal(input logic [4:0] t, input logic [7:0] pl[$], input bit singles);
      int i = 0;
      int nb;
      while (i < pl.size()) begin
         nb = (pl.size() - i == 1) ? 1 : 2;
         if (singles) begin
            step_lfsr();
            if (lfsr[0]) nb = 1;
         end
         drive_word(pl[i], (nb == 2) ? pl[i+1] : 8'hEE, nb, i == 0,
                    i + nb == pl.size(), t);
         i += nb;
      end
   endtask

   // Monitor: pops expected bytes and compares each lane (R7 R8 R9)
   logic [31:0] h_data;
   logic [3:0]  h_be;
   logic        h_last;
   bit          h_pend = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (h_pend)
            check(out_valid && out_data == h_data && out_be == h_be && out_last == h_last,
                  "R9 hold", int'(out_data), int'(h_data));
         step_lfsr();
         out_ready = stall ? 1'b0 : (lfsr[3:2] != 2'b00);
         h_pend = out_valid && !out_ready;
         h_data = out_data; h_be = out_be; h_last = out_last;
         if (out_valid && out_ready) begin
            bit lastseen = 1'b0;
            for (int k = 0; k < 4; k++) begin
               if (out_be[3-k]) begin
                  exp_t e;
                  logic [7:0] a;
                  a = out_data[31-8*k -: 8];
                  if (expq.size() == 0) begin
                     check(1'b0, "R7 unexpected byte", int'(a), 0);
                  end else begin
                     e = expq.pop_front();
                     if (e.req == 2)      check(a == e.b, "R2 start code", int'(a), int'(e.b));
                     else if (e.req == 3) check(a == e.b, "R3 header", int'(a), int'(e.b));
                     else if (e.req == 4) check(a == e.b, "R4 escape", int'(a), int'(e.b));
                     else                 check(a == e.b, "R7 payload R5 R6", int'(a), int'(e.b));
                     if (e.first) check(k == 0, "R2 lane", k, 0);
                     lastseen = e.last;
                  end
               end
            end
            check(out_last == lastseen, "R8 last flag", int'(out_last), int'(lastseen));
            if (!out_last) check(out_be == 4'hF, "R7 full word", int'(out_be), 15);
         end
      end
   end

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] p[$];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!out_valid, "R1 out_valid", int'(out_valid), 0);
      check(out_be == 4'h0, "R1 out_be", int'(out_be), 0);
      check(in_ready, "R1 in_ready", int'(in_ready), 1);
      mon_on = 1'b1;
      stall = 1'b0;

      // R3 R6: parameter set with a single-byte tail word
      p = '{8'h42, 8'h00, 8'h1F};
      send_nal(5'd7, p, 0);
      // R4 R5: zero pair split over words, escape due on next word
      p = '{8'h00, 8'h00, 8'h01, 8'h55};
      send_nal(5'd5, p, 0);
      p = '{8'h77, 8'h00, 8'h00, 8'h02};
      send_nal(5'd8, p, 0);
      // R4: long zero run, repeated escapes
      p = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80};
      send_nal(5'd1, p, 0);
      // R5: unit ends in zeros, next unit opens with 0x01 (no escape expected)
      p = '{8'h11, 8'h00, 8'h00};
      send_nal(5'd1, p, 0);
      p = '{8'h01, 8'h02, 8'h00, 8'h00, 8'h03};
      send_nal(5'd5, p, 0);
      // R8: one-byte unit flushes a short word
      p = '{8'h9A};
      send_nal(5'd8, p, 0);

      // R10: back-pressure, buffer fills after two words
      repeat (12) @(negedge clk);
      stall = 1'b1;
      @(negedge clk);
      drive_word(8'h11, 8'h22, 2, 1, 0, 5'd1);
      check(in_ready, "R10 ready at 7 bytes", int'(in_ready), 1);
      drive_word(8'h33, 8'h44, 2, 0, 0, 5'd1);
      in_data = 16'h5566; in_nbytes = 2'd2; in_first = 0; in_last = 1; in_valid = 1'b1;
      for (int w = 0; w < 4; w++) begin
         check(!in_ready, "R10 ready low at 9 bytes", int'(in_ready), 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      stall = 1'b0;
      drive_word(8'h55, 8'h66, 2, 0, 1, 5'd1);

      // Mixed random traffic with stalls and single-byte words (R4 R5 R6 R7 R8 R9)
      for (int n = 0; n < 60; n++) begin
         int len;
         logic [4:0] ty;
         step_lfsr();
         len = 1 + int'(lfsr[4:0] % 5'd20);
         case (n % 4)
            0: ty = 5'd7;
            1: ty = 5'd8;
            2: ty = 5'd5;
            default: ty = 5'd1;
         endcase
         p = {};
         for (int i = 0; i < len; i++) begin
            step_lfsr();
            if (lfsr[2:0] < 3'd5) p.push_back(8'h00);
            else p.push_back({6'd0, lfsr[9:8]} + ((lfsr[12]) ? 8'h40 : 8'h00));
         end
         send_nal(ty, p, 1);
      end

      for (int w = 0; w < 2000 && (expq.size() != 0 || out_valid); w++) @(negedge clk);
      // R8: every unit fully flushed
      check(expq.size() == 0, "R8 all bytes flushed", expq.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule